// File: doc/BRIEF.md
# Isolated Link Status Frame Transmitter

This block sits on the primary side of an isolated power monitor. It sends measured values and fault flags, one way, to a controller on the far side of a transformer. It takes parallel inputs and builds a serial frame. The frame holds a summary status byte, input voltage, auxiliary voltage, input current, fuse-node voltage and an 8-bit checksum. The block then drives the frame onto a complementary pin pair. Nothing comes back over the link.

Each symbol occupies a slot of five equal positions. A data slot carries two bits as a short pulse in one of positions 0 to 3. The first slot of a frame holds a pulse in position 4, which marks the start. Successive pulses go out on the positive and negative pins in turn, so the transformer stays balanced. A frame begins once the enable is seen high while the link is idle. Frames follow each other with no gap for as long as the enable stays high.

Top module: `iso_link_tx`

## Requirements
- R1: During and after reset, with the enable low, both `tx_p_o` and `tx_n_o` are 0 and no frame is in progress.
- R2: `tx_p_o` and `tx_n_o` are never 1 in the same cycle.
- R3: Pulses alternate between the pins. The first pulse after reset goes out on `tx_p_o`. Every later pulse uses the other pin from the pulse before it, across frame boundaries as well.
- R4: A slot is 5 positions of POS_CYC cycles each. A pulse is high for the first PULSE_CYC cycles of its position. A two-bit symbol value v (first frame bit as MSB) puts the pulse in position v. The frame-start slot puts it in position 4.
- R5: The frame bits are sent MSB first in this order: status byte, `vin_i` (10 bits), `aux_i` (AUX_BITS, 8 or 10), `cur_i` (8), `fuse_i` (8), checksum (8). The status byte is {any-fault, stat_i[6:0]}, where stat_i[6]=fuse fail, [5]=brownout, [4]=overcurrent, [3]=overvoltage, [2]=seat, [1]=inrush complete and [0]=undervoltage.
- R6: The any-fault bit is 1 exactly when at least one bit of `stat_i` is 1. It is 0 for an all-zero status.
- R7: The checksum covers the payload, meaning every frame bit before the checksum, with payload bit j counted from the payload LSB. Checksum bit i is the XOR of all payload bits j with j mod 8 = i.
- R8: All inputs are captured in the cycle a frame starts. Changes during a frame do not alter that frame.
- R9: A clock edge that sees `en_i` high while idle starts a frame, and the first cycle of the start slot follows that edge. The outputs are registered, so they lag the slot timing by one cycle. If `en_i` is high at the last cycle of a frame, the next frame starts at once. Otherwise the frame finishes and the pins stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Send frames while high |
| stat_i | input | 7 | Status flags, mapping in R5 |
| vin_i | input | 10 | Input voltage sample |
| aux_i | input | AUX_BITS | Auxiliary voltage sample |
| cur_i | input | 8 | Input current sample |
| fuse_i | input | 8 | Fuse-node voltage sample |
| tx_p_o | output | 1 | Positive-polarity pulse pin |
| tx_n_o | output | 1 | Negative-polarity pulse pin |

## Verification
If the slot or position counters drift, a pulse lands in the wrong position. That shows on the pins within one position time, POS_CYC cycles, of the first affected slot. A polarity register that fails to toggle puts two pulses in a row on the same pin, and this is visible at the very next pulse. A fault in the captured frame, the any-fault bit or the checksum appears as a misplaced pulse in the slot that carries the bad pair. In the worst case that is the last slot, about one frame after the cause. The bench compares every output cycle against a model, so any such deviation is reported in the cycle it first reaches a pin.

// File: rtl/isl_pkg.sv
package isl_pkg;
  localparam int NPOS = 5;
  localparam logic [2:0] SYNC_POS = 3'd4;
  localparam int STAT_W = 7;

  function automatic int frame_bits(int aux_bits);
    return 1 + STAT_W + 10 + aux_bits + 8 + 8 + 8;
  endfunction

  function automatic logic any_fault(logic [STAT_W-1:0] s);
    return |s;
  endfunction
endpackage

// File: rtl/isl_frame_pack.sv
module isl_frame_pack #(
  parameter int AUX_BITS = 10,
  localparam int FRAME_W = isl_pkg::frame_bits(AUX_BITS),
  localparam int PAY_W   = FRAME_W - 8
) (
  input  logic [isl_pkg::STAT_W-1:0] stat_i,
  input  logic [9:0]                 vin_i,
  input  logic [AUX_BITS-1:0]        aux_i,
  input  logic [7:0]                 cur_i,
  input  logic [7:0]                 fuse_i,
  output logic [FRAME_W-1:0]         frame_o
);
  function automatic logic [7:0] fold8(logic [PAY_W-1:0] p);
    logic [7:0] c;
    c = '0;
    for (int j = 0; j < PAY_W; j++) c[j % 8] = c[j % 8] ^ p[j];
    return c;
  endfunction

  logic [PAY_W-1:0] payload;

  always_comb begin
    payload = {isl_pkg::any_fault(stat_i), stat_i, vin_i, aux_i, cur_i, fuse_i};
    frame_o = {payload, fold8(payload)};
  end
endmodule

// File: rtl/isl_slot_timer.sv
module isl_slot_timer #(
  parameter int POS_CYC = 4,
  parameter int NSLOT   = 27,
  localparam int CW = $clog2(POS_CYC),
  localparam int SW = $clog2(NSLOT)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  output logic          busy_o,
  output logic          load_o,
  output logic [SW-1:0] slot_o,
  output logic [2:0]    pos_o,
  output logic [CW-1:0] cnt_o
);
  logic cnt_wrap, pos_wrap, frame_last;

  always_comb begin
    cnt_wrap   = busy_o && (cnt_o == CW'(POS_CYC - 1));
    pos_wrap   = cnt_wrap && (pos_o == 3'(isl_pkg::NPOS - 1));
    frame_last = pos_wrap && (slot_o == SW'(NSLOT - 1));
    load_o     = en_i && (!busy_o || frame_last);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      slot_o <= '0;
      pos_o  <= '0;
      cnt_o  <= '0;
    end else if (load_o) begin
      busy_o <= 1'b1;
      slot_o <= '0;
      pos_o  <= '0;
      cnt_o  <= '0;
    end else if (busy_o) begin
      busy_o <= !frame_last;
      cnt_o  <= cnt_wrap ? '0 : cnt_o + 1'b1;
      if (cnt_wrap) pos_o <= pos_wrap ? '0 : pos_o + 3'd1;
      if (pos_wrap) slot_o <= frame_last ? '0 : slot_o + 1'b1;
    end
  end

  a_r4_pos_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_o < 3'(isl_pkg::NPOS));
  a_r9_frame_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_last && en_i) |=> (busy_o && slot_o == '0 && pos_o == '0));
  a_r9_frame_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_last && !en_i) |=> !busy_o);
endmodule

// File: rtl/isl_pulse_drive.sv
module isl_pulse_drive #(
  parameter int POS_CYC   = 4,
  parameter int PULSE_CYC = 2,
  parameter int FRAME_W   = 52,
  parameter int NSLOT     = 27,
  localparam int CW = $clog2(POS_CYC),
  localparam int SW = $clog2(NSLOT)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               busy_i,
  input  logic [SW-1:0]      slot_i,
  input  logic [2:0]         pos_i,
  input  logic [CW-1:0]      cnt_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               tx_p_o,
  output logic               tx_n_o
);
  logic [2:0] target;
  logic       pulse_now, pulse_end, pol_q;
  int         hi_idx;

  always_comb begin
    hi_idx = FRAME_W + 1 - 2 * int'(slot_i);
    if (slot_i == '0) begin
      hi_idx = FRAME_W - 1;
      target = isl_pkg::SYNC_POS;
    end else begin
      target = {1'b0, frame_i[hi_idx], frame_i[hi_idx-1]};
    end
    pulse_now = busy_i && (pos_i == target) && (int'(cnt_i) < PULSE_CYC);
    pulse_end = pulse_now && (cnt_i == CW'(PULSE_CYC - 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_q  <= 1'b0;
      tx_p_o <= 1'b0;
      tx_n_o <= 1'b0;
    end else begin
      tx_p_o <= pulse_now && !pol_q;
      tx_n_o <= pulse_now && pol_q;
      if (pulse_end) pol_q <= !pol_q;
    end
  end

  // Observer state for the polarity-order assertions
  logic p_d, n_d, last_was_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_d <= 1'b0; n_d <= 1'b0; last_was_n <= 1'b1;
    end else begin
      p_d <= tx_p_o; n_d <= tx_n_o;
      if (tx_p_o && !p_d) last_was_n <= 1'b0;
      else if (tx_n_o && !n_d) last_was_n <= 1'b1;
    end
  end

  a_r2_not_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_p_o && tx_n_o));
  a_r3_p_after_n: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_p_o && !p_d) |-> last_was_n);
  a_r3_n_after_p: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_n_o && !n_d) |-> !last_was_n);
  a_r4_pulse_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_p_o || tx_n_o) |-> (int'($past(cnt_i)) < PULSE_CYC && $past(busy_i)));
  a_r9_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(busy_i) |-> (!tx_p_o && !tx_n_o));
endmodule

// File: rtl/iso_link_tx.sv
module iso_link_tx #(
  parameter int AUX_BITS  = 10,
  parameter int POS_CYC   = 4,
  parameter int PULSE_CYC = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       en_i,
  input  logic [isl_pkg::STAT_W-1:0] stat_i,
  input  logic [9:0]                 vin_i,
  input  logic [AUX_BITS-1:0]        aux_i,
  input  logic [7:0]                 cur_i,
  input  logic [7:0]                 fuse_i,
  output logic                       tx_p_o,
  output logic                       tx_n_o
);
  localparam int FRAME_W = isl_pkg::frame_bits(AUX_BITS);
  localparam int NSLOT   = 1 + FRAME_W / 2;
  localparam int CW      = $clog2(POS_CYC);
  localparam int SW      = $clog2(NSLOT);

  logic [FRAME_W-1:0] frame_next, frame_q;
  logic               busy, load;
  logic [SW-1:0]      slot;
  logic [2:0]         pos;
  logic [CW-1:0]      cnt;

  isl_frame_pack #(.AUX_BITS(AUX_BITS)) u_pack (
    .stat_i(stat_i), .vin_i(vin_i), .aux_i(aux_i), .cur_i(cur_i),
    .fuse_i(fuse_i), .frame_o(frame_next));

  isl_slot_timer #(.POS_CYC(POS_CYC), .NSLOT(NSLOT)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .busy_o(busy),
    .load_o(load), .slot_o(slot), .pos_o(pos), .cnt_o(cnt));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) frame_q <= '0;
    else if (load) frame_q <= frame_next;
  end

  isl_pulse_drive #(.POS_CYC(POS_CYC), .PULSE_CYC(PULSE_CYC),
                    .FRAME_W(FRAME_W), .NSLOT(NSLOT)) u_drive (
    .clk_i(clk_i), .rst_ni(rst_ni), .busy_i(busy), .slot_i(slot),
    .pos_i(pos), .cnt_i(cnt), .frame_i(frame_q),
    .tx_p_o(tx_p_o), .tx_n_o(tx_n_o));

  a_r8_hold_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load |=> $stable(frame_q));
  a_r6_summary_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> (frame_q[FRAME_W-1] == ($past(stat_i) != '0)));
endmodule

// File: tb/test_iso_link_tx.sv
module test_iso_link_tx;
  localparam int AUXB = 10, POS = 4, PW = 2;
  localparam int PAYB = 1 + 7 + 10 + AUXB + 16;
  localparam int FRB  = PAYB + 8;
  localparam int FCYC = (1 + FRB / 2) * 5 * POS;

  logic clk = 0, rst_n = 0, en = 0;
  logic [6:0] stat = '0;
  logic [9:0] vin = '0;
  logic [AUXB-1:0] aux = '0;
  logic [7:0] cur = '0, fuse = '0;
  logic tx_p, tx_n;

  iso_link_tx #(.AUX_BITS(AUXB), .POS_CYC(POS), .PULSE_CYC(PW)) i_iso_link_tx (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .stat_i(stat), .vin_i(vin),
    .aux_i(aux), .cur_i(cur), .fuse_i(fuse), .tx_p_o(tx_p), .tx_n_o(tx_n));

  always #4 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  string tag = "R1";
  bit done = 0;

  // Reference model: bit list as a queue, timing from a frame-cycle integer
  bit q_fr[$];
  bit busy_m = 0, pol_m = 0, exp_p = 0, exp_n = 0;
  int t_m = 0;

  function automatic void build_frame();
    bit pay[$];
    bit ck[8];
    bit any;
    any = 0;
    for (int i = 0; i < 7; i++) if (stat[i]) any = 1;
    pay.push_back(any);
    for (int i = 6; i >= 0; i--) pay.push_back(stat[i]);
    for (int i = 9; i >= 0; i--) pay.push_back(vin[i]);
    for (int i = AUXB-1; i >= 0; i--) pay.push_back(aux[i]);
    for (int i = 7; i >= 0; i--) pay.push_back(cur[i]);
    for (int i = 7; i >= 0; i--) pay.push_back(fuse[i]);
    for (int i = 0; i < 8; i++) ck[i] = 0;
    for (int k = 0; k < pay.size(); k++) begin
      int j;
      j = pay.size() - 1 - k;   // index counted from payload LSB
      ck[j % 8] ^= pay[k];
    end
    q_fr = pay;
    for (int i = 7; i >= 0; i--) q_fr.push_back(ck[i]);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_m = 0; pol_m = 0; exp_p = 0; exp_n = 0; t_m = 0;
    end else begin
      int s, p, c, tgt;
      bit pl;
      s = t_m / (5 * POS); p = (t_m / POS) % 5; c = t_m % POS;
      tgt = (s == 0) ? 4 : 2 * q_fr[2*(s-1)] + q_fr[2*(s-1)+1];
      pl = busy_m && (p == tgt) && (c < PW);
      exp_p = pl && !pol_m;
      exp_n = pl && pol_m;
      if (pl && c == PW - 1) pol_m = !pol_m;
      if (busy_m) begin
        if (t_m == FCYC - 1) begin
          if (en) begin build_frame(); t_m = 0; end
          else busy_m = 0;
        end else t_m++;
      end else if (en) begin
        busy_m = 1; t_m = 0; build_frame();
      end
    end
  end

  // Per-cycle comparison, pin exclusivity and polarity order
  bit last_n = 1, pp = 0, pn = 0;
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      checks++;
      if (tx_p !== exp_p || tx_n !== exp_n) begin
        errors++;
        $display("FAIL %s: cycle %0d pins p/n=%b%b expected %b%b", tag, cycles, tx_p, tx_n, exp_p, exp_n);
      end
      checks++;
      if (tx_p && tx_n) begin
        errors++;
        $display("FAIL R2: both pins high actual 11 expected not 11");
      end
      if ((tx_p && !pp) || (tx_n && !pn)) begin
        checks++;
        if ((tx_p && !last_n) || (tx_n && last_n)) begin
          errors++;
          $display("FAIL R3: pulse on %s after %s, expected other pin",
                   tx_p ? "p" : "n", last_n ? "n" : "p");
        end
        last_n = tx_n;
      end
      pp = tx_p; pn = tx_n;
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not end, actual hung expected finished");
      finish_run();
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_in(logic [6:0] s, logic [9:0] v, logic [AUXB-1:0] a, logic [7:0] c, logic [7:0] f);
    stat = s; vin = v; aux = a; cur = c; fuse = f;
  endtask

  initial begin
    tag = "R1";
    wait_cyc(3);
    checks++;
    if (tx_p !== 0 || tx_n !== 0) begin
      errors++; $display("FAIL R1: in reset pins %b%b expected 00", tx_p, tx_n);
    end
    rst_n = 1;
    wait_cyc(20);
    // R5 R4: basic frame with distinct fields, status all zero (R6 any=0)
    tag = "R5";
    set_in(7'h00, 10'h2A5, 10'h15A, 8'hC3, 8'h3C);
    en = 1;
    wait_cyc(FCYC);
    // R6: single status bits, back-to-back frames (R9)
    tag = "R6";
    for (int b = 0; b < 7; b++) begin
      set_in(7'(1 << b), 10'(37 * b + 1), 10'(91 * b), 8'(b * 17), 8'(255 - b));
      wait_cyc(FCYC);
    end
    // R7: checksum over varied patterns
    tag = "R7";
    set_in(7'h7F, 10'h3FF, 10'h3FF, 8'hFF, 8'hFF); wait_cyc(FCYC);
    set_in(7'h55, 10'h001, 10'h200, 8'h80, 8'h01); wait_cyc(FCYC);
    // R8: change inputs in the middle of a frame
    tag = "R8";
    wait_cyc(FCYC / 3);
    set_in(7'h2A, 10'h155, 10'h0F0, 8'h5A, 8'hA5);
    wait_cyc(FCYC / 3);
    set_in(7'h11, 10'h0AA, 10'h30F, 8'h12, 8'h34);
    wait_cyc(FCYC);
    // R9: drop enable mid-frame; frame completes, then idle low
    tag = "R9";
    wait_cyc(FCYC / 2);
    en = 0;
    wait_cyc(FCYC);
    for (int k = 0; k < 200; k++) begin
      checks++;
      if (tx_p !== 0 || tx_n !== 0) begin
        errors++; $display("FAIL R9: idle pins %b%b expected 00", tx_p, tx_n);
      end
      wait_cyc(1);
    end
    // R3 R9: restart, polarity continues from previous frames
    tag = "R3";
    set_in(7'h08, 10'h123, 10'h321, 8'h44, 8'h99);
    en = 1; wait_cyc(FCYC + 10); en = 0;
    wait_cyc(FCYC + 10);
    // R1: reset mid-stream clears state, first pulse on p again
    tag = "R1";
    en = 1; wait_cyc(FCYC / 2);
    rst_n = 0; wait_cyc(2);
    checks++;
    if (tx_p !== 0 || tx_n !== 0) begin
      errors++; $display("FAIL R1: in reset pins %b%b expected 00", tx_p, tx_n);
    end
    last_n = 1; pp = 0; pn = 0;
    rst_n = 1;
    tag = "R4";
    wait_cyc(FCYC + 30);
    en = 0;
    wait_cyc(FCYC + 10);
    done = 1;
    finish_run();
  end
endmodule